// File: doc/BRIEF.md
# Two-Key Ordered Unlock Controller

This block watches two push-key strobes, a first key and a second key, and raises a one-cycle grant pulse when the first key is followed on the very next sampled clock by the second key. It is a Moore machine with three states: resting, armed (first key seen, second key expected), and open (sequence accepted). Any cycle in the armed state that lacks the second key drops the machine back to rest. After the open state the machine returns to rest without looking at its inputs.

The key inputs are expected to be clean, single-cycle, already synchronised strobes. The grant is decoded from the state register alone, so it changes only after a rising clock edge. Conflicts are settled by the current state: with both keys high at rest, the first key arms the machine; with both keys high while armed, the second key is accepted.

Top module: `seq_unlock`

## Requirements
- R1: A synchronous active-high reset puts the machine at rest; in the cycle after any clock edge that sees reset high, grant is low, whatever the keys are doing.
- R2: At rest, a first-key strobe moves the machine to armed (grant stays low); with no first key the machine stays at rest, and a second key alone has no effect.
- R3: When armed, a second-key strobe moves the machine to open, and grant is high during the clock cycle that follows that edge.
- R4: When armed, a cycle without the second key (no key, or the first key alone) returns the machine to rest with grant low, so a later second key alone grants nothing.
- R5: Grant is high for exactly one clock cycle per accepted sequence; from open the machine always goes to rest, and a first key seen while open does not arm it.
- R6: At rest, both keys high together count as a first-key strobe and arm the machine.
- R7: When armed, both keys high together count as a second-key strobe and open the machine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| key_first_i | input | 1 | First-key strobe, one cycle per press |
| key_second_i | input | 1 | Second-key strobe, one cycle per press |
| grant_o | output | 1 | One-cycle grant pulse, high while open |

## Verification
Two functions meet in one cycle when both key strobes are high together: the arm path, which listens to the first key, and the accept path, which listens to the second key. The bench drives both keys at once at rest, while armed and while open. It judges the result by the grant seen one edge later, and by a follow-up second key alone that reveals whether the machine was left armed or at rest.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_REST  = 2'b00,
    ST_ARMED = 2'b01,
    ST_OPEN  = 2'b10,
    ST_SPARE = 2'b11
  } lock_state_t;

  typedef struct packed {
    logic arm;
    logic accept;
    logic abort;
    logic leave;
  } lock_event_t;

  // Map any code to one of the three live states; the spare code reads as rest.
  function automatic lock_state_t live_state(input lock_state_t s);
    case (s)
      ST_ARMED: return ST_ARMED;
      ST_OPEN:  return ST_OPEN;
      default:  return ST_REST;
    endcase
  endfunction

  function automatic lock_event_t classify(input lock_state_t s,
                                           input logic k1,
                                           input logic k2);
    lock_event_t ev;
    lock_state_t ls;
    ls = live_state(s);
    ev.arm    = (ls == ST_REST)  && k1;
    ev.accept = (ls == ST_ARMED) && k2;
    ev.abort  = (ls == ST_ARMED) && !k2;
    ev.leave  = (ls == ST_OPEN);
    return ev;
  endfunction

  function automatic lock_state_t step(input lock_event_t ev);
    if (ev.accept) return ST_OPEN;
    if (ev.arm)    return ST_ARMED;
    return ST_REST;
  endfunction

  function automatic logic grant_of(input lock_state_t s);
    return live_state(s) == ST_OPEN;
  endfunction

endpackage

// File: rtl/seq_unlock_event.sv
module seq_unlock_event
  import seq_unlock_pkg::*;
(
  input  lock_state_t state_i,
  input  logic        key_first_i,
  input  logic        key_second_i,
  output lock_event_t event_o
);
  always_comb event_o = classify(state_i, key_first_i, key_second_i);
endmodule

// File: rtl/seq_unlock_next.sv
module seq_unlock_next
  import seq_unlock_pkg::*;
(
  input  lock_event_t event_i,
  output lock_state_t next_o
);
  always_comb next_o = step(event_i);
endmodule

// File: rtl/seq_unlock_state.sv
module seq_unlock_state
  import seq_unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_t next_i,
  output lock_state_t state_o
);
  always_ff @(posedge clk) begin
    if (rst) state_o <= ST_REST;
    else     state_o <= next_i;
  end
endmodule

// File: rtl/seq_unlock_out.sv
module seq_unlock_out
  import seq_unlock_pkg::*;
(
  input  lock_state_t state_i,
  output logic        grant_o,
  output logic        armed_o
);
  always_comb begin
    grant_o = grant_of(state_i);
    armed_o = live_state(state_i) == ST_ARMED;
  end
endmodule

// File: rtl/seq_unlock.sv
module seq_unlock
  import seq_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic key_first_i,
  input  logic key_second_i,
  output logic grant_o
);
  lock_state_t state_q;
  lock_state_t state_d;
  lock_event_t ev;
  logic        armed_w;
  logic        open_w;

  seq_unlock_event u_event (
    .state_i     (state_q),
    .key_first_i (key_first_i),
    .key_second_i(key_second_i),
    .event_o     (ev)
  );

  seq_unlock_next u_next (
    .event_i(ev),
    .next_o (state_d)
  );

  seq_unlock_state u_state (
    .clk    (clk),
    .rst    (rst),
    .next_i (state_d),
    .state_o(state_q)
  );

  seq_unlock_out u_out (
    .state_i(state_q),
    .grant_o(open_w),
    .armed_o(armed_w)
  );

  assign grant_o = open_w;
endmodule

// File: rtl/seq_unlock_chk.sv
module seq_unlock_chk (
  input logic clk,
  input logic rst,
  input logic key_first_i,
  input logic key_second_i,
  input logic grant_o,
  input logic armed_w
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!grant_o && !armed_w)); // R1
  AST_REST_ARMS: assert property (@(posedge clk) disable iff (rst)
    (!armed_w && !grant_o && key_first_i) |=> armed_w); // R2
  AST_ARMED_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (armed_w && key_second_i) |=> grant_o); // R3
  AST_ARMED_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (armed_w && !key_second_i) |=> (!armed_w && !grant_o)); // R4
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> (!grant_o && !armed_w)); // R5
  AST_GRANT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> $past(armed_w && key_second_i)); // R3
  AST_BOTH_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (!armed_w && !grant_o && key_first_i && key_second_i) |=> (armed_w && !grant_o)); // R6
  AST_BOTH_ARMED: assert property (@(posedge clk) disable iff (rst)
    (armed_w && key_first_i && key_second_i) |=> grant_o); // R7
endmodule

bind seq_unlock seq_unlock_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_first_i (key_first_i),
  .key_second_i(key_second_i),
  .grant_o     (grant_o),
  .armed_w     (armed_w)
);

// File: tb/test_seq_unlock.sv
module test_seq_unlock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic k1 = 1'b0;
  logic k2 = 1'b0;
  logic grant;
  int   n_checks = 0;
  int   n_errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  seq_unlock i_seq_unlock (
    .clk         (clk),
    .rst         (rst),
    .key_first_i (k1),
    .key_second_i(k2),
    .grant_o     (grant)
  );

  // {first key, second key, expected grant after the edge}
  localparam int NVEC = 18;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b100, 3'b011, 3'b000, 3'b100, 3'b000,
    3'b010, 3'b100, 3'b100, 3'b010, 3'b110, 3'b111,
    3'b100, 3'b010, 3'b100, 3'b011, 3'b110, 3'b010
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 6:      return "R2";
      1, 2, 15:  return "R3";
      3, 16:     return "R5";
      4, 5, 9:   return "R4";
      7, 8:      return "R4";
      10:        return "R6";
      11:        return "R7";
      12, 13:    return "R5";
      14:        return "R2";
      default:   return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic exp);
    n_checks++;
    if (grant !== exp) begin
      n_errors++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp, $time);
    end
  endtask

  // drive keys at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cycle(input logic a, input logic b);
    k1 = a;
    k2 = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: grant=%b expected=finished", grant);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(1'b1, 1'b1);            // reset held with both keys high
    check("R1", 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][2], VEC[i][1]);
      check(tag_of(i), VEC[i][0]);
    end

    // R1: reset while armed discards the arm
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    rst = 1'b1;
    cycle(1'b0, 1'b1);
    check("R1", 1'b0);
    rst = 1'b0;
    cycle(1'b0, 1'b1);
    check("R1", 1'b0);

    // R1: reset while open clears grant after the edge
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b1);
    check("R3", 1'b1);
    rst = 1'b1;
    cycle(1'b1, 1'b1);
    check("R1", 1'b0);
    rst = 1'b0;

    // R4: arm, then a long gap, then the second key alone
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    check("R4", 1'b0);

    // R5: back-to-back sequences each give a single pulse
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b1);
    check("R5", 1'b1);
    cycle(1'b1, 1'b0);
    check("R5", 1'b0);
    cycle(1'b1, 1'b0);
    check("R5", 1'b0);
    cycle(1'b0, 1'b1);
    check("R5", 1'b1);
    cycle(1'b0, 1'b0);
    check("R5", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule